// File: doc/BRIEF.md
# Descriptor Ring Transmit DMA

This block moves outgoing frames from memory to a MAC transmit port. Software builds a ring of buffer descriptors in memory. Each descriptor is four 32-bit words: status, then control, then buffer address, then a next pointer. Software hands a descriptor to the engine by setting its ownership bit. The engine walks the ring in address order. For every descriptor it owns, it reads the frame buffer word by word and streams it out as bytes with valid/ready/last. It then writes the status word back with ownership cleared and flags completion in a sticky status register that can raise an interrupt.

The traversal is a pure ring. The next-pointer word is not used; a descriptor carrying the end-of-ring flag sends the engine back to the programmed base. A configuration bit doubles the descriptor stride to eight words, which leaves four spare words after each descriptor for software's own bookkeeping. When the engine meets a descriptor that software still owns, it parks itself and reports "buffer unavailable". It touches memory again only after software writes the poll-demand register, which makes it re-read that same descriptor.

The register port is word-indexed. Index 0 is control: bit 0 enables the engine and bit 1 enables the eight-word stride. Index 1 is the ring base, given as a byte address. A write to index 2 is a poll demand. Index 3 is status: bit 0 means a frame was sent and bit 1 means a buffer was unavailable; both bits are write-one-to-clear. Index 4 is the interrupt mask, using the same bit positions as status.

Top module: `ring_tx_dma`

## Requirements
- R1: After reset, tx_valid, mem_req and irq are low and the status register reads 0.
- R2: Starting at the current descriptor word address P, the engine reads the status word at P, the control word at P+1 and the buffer byte address at P+2. It processes the descriptor only if status bit 31 is 1. The frame length in bytes is control bits 10:0, and control bit 30 is the end-of-ring flag.
- R3: The frame bytes leave in buffer order, low byte of each word first. tx_last is high on the final byte only. While tx_valid is high and tx_ready is low, tx_data and tx_last hold, and no byte is dropped or repeated.
- R4: After the final byte is accepted, the engine writes word P with bit 31 cleared, bits 15:0 equal to the frame length and all other bits zero. Status bit 0 then becomes set.
- R5: A descriptor of length 0 emits no byte but is still written back and still sets status bit 0.
- R6: After a write-back, the next descriptor is at P+4, or at P+8 when control bit 1 is set. If the end-of-ring flag was set, the next descriptor is at the ring base instead.
- R7: A descriptor whose status bit 31 is 0 sets status bit 1. The engine then makes no memory access and emits no data until a poll-demand write, after which it re-reads the same descriptor.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. irq is high exactly when status AND mask is non-zero.
- R9: Ring-base writes are ignored while the engine is enabled. Enabling the engine loads the current descriptor from the base, and the engine waits for a poll demand before any memory access. While disabled, it makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid in the granting cycle |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts byte |
| irq | output | 1 | Interrupt request |

## Verification
A poll-demand write lands on one clock edge, and the status fetch is requested on the next cycle. A frame's status bit is set on the edge after its write-back grant. Because the memory model inserts grant stalls, the bench does not count a fixed number of cycles to completion. It polls the status register, bounded, until the expected bit appears, and only then compares the captured bytes, write-back records and last fetch address with values worked out from the descriptors. Register reads are combinational, and irq follows a mask or clear write on the next edge, so those are sampled at the falling edge right after the write.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [2:0] {
    W_OFF,
    W_WAIT,
    W_STAT,
    W_CTRL,
    W_BUF,
    W_DATA,
    W_DRAIN,
    W_WB
  } walk_t;

  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 30;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_POLL = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;
  localparam logic [2:0] RA_MASK = 3'd4;

endpackage

// File: rtl/txd_regs.sv
module txd_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          set_done,
  input  logic          set_unav,
  output logic          cfg_en,
  output logic          cfg_gap,
  output logic [AW-1:0] base_w,
  output logic          poll,
  output logic          irq
);
  import txd_pkg::*;

  logic [1:0]    ctrl_q, ctrl_n;
  logic [AW-1:0] base_q, base_n;
  logic [1:0]    stat_q, stat_n;
  logic [1:0]    mask_q, mask_n;
  logic          unused_wd;

  assign unused_wd = ^reg_wdata;

  always_comb begin
    ctrl_n = ctrl_q;
    base_n = base_q;
    mask_n = mask_q;
    stat_n = stat_q;
    if (reg_we) begin
      case (reg_addr)
        RA_CTRL: ctrl_n = reg_wdata[1:0];
        RA_BASE: if (!ctrl_q[0]) base_n = reg_wdata[AW+1:2];
        RA_MASK: mask_n = reg_wdata[1:0];
        RA_STAT: stat_n = stat_q & ~reg_wdata[1:0];
        default: ;
      endcase
    end
    stat_n = stat_n | {set_unav, set_done};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      base_q <= base_n;
      stat_q <= stat_n;
      mask_q <= mask_n;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {30'd0, ctrl_q};
      RA_BASE: reg_rdata = 32'({base_q, 2'b00});
      RA_STAT: reg_rdata = {30'd0, stat_q};
      RA_MASK: reg_rdata = {30'd0, mask_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  assign cfg_en  = ctrl_q[0];
  assign cfg_gap = ctrl_q[1];
  assign base_w  = base_q;
  assign poll    = reg_we && (reg_addr == RA_POLL);
  assign irq     = |(stat_q & mask_q);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> stat_q[0]) else $error("done flag not set"); // R4

  AST_BASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] |=> $stable(base_q)) else $error("base changed while enabled"); // R9

endmodule

// File: rtl/txd_walker.sv
module txd_walker #(
  parameter int AW    = 16,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_gap,
  input  logic [AW-1:0] base_w,
  input  logic          poll,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  input  logic          up_free,
  output logic          up_load,
  output logic [2:0]    up_nb,
  output logic          up_last,
  output logic          set_done,
  output logic          set_unav,
  output logic          suspended
);
  import txd_pkg::*;

  localparam logic [AW-1:0]    STRIDE_N = AW'(4);
  localparam logic [AW-1:0]    STRIDE_G = AW'(8);
  localparam logic [LEN_W-1:0] WORD_B   = LEN_W'(4);

  walk_t            st_q, st_n;
  logic [AW-1:0]    ptr_q, ptr_n;
  logic [AW-1:0]    bp_q, bp_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             eor_q, eor_n;
  logic             tail;
  logic             unused_rd;

  assign unused_rd = ^mem_rdata;
  assign tail      = (rem_q <= WORD_B);

  always_comb begin
    st_n      = st_q;
    ptr_n     = ptr_q;
    bp_n      = bp_q;
    len_n     = len_q;
    rem_n     = rem_q;
    eor_n     = eor_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = 32'd0;
    up_load   = 1'b0;
    up_nb     = tail ? rem_q[2:0] : 3'd4;
    up_last   = tail;
    set_done  = 1'b0;
    set_unav  = 1'b0;
    case (st_q)
      W_OFF: begin
        ptr_n = base_w;
        if (cfg_en) st_n = W_WAIT;
      end
      W_WAIT: begin
        if (poll) st_n = W_STAT;
      end
      W_STAT: begin
        mem_req = 1'b1;
        if (mem_gnt) begin
          if (mem_rdata[OWN_BIT]) begin
            st_n = W_CTRL;
          end else begin
            set_unav = 1'b1;
            st_n     = W_WAIT;
          end
        end
      end
      W_CTRL: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + AW'(1);
        if (mem_gnt) begin
          len_n = mem_rdata[LEN_W-1:0];
          eor_n = mem_rdata[EOR_BIT];
          st_n  = W_BUF;
        end
      end
      W_BUF: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + AW'(2);
        if (mem_gnt) begin
          bp_n  = mem_rdata[AW+1:2];
          rem_n = len_q;
          st_n  = (len_q == '0) ? W_WB : W_DATA;
        end
      end
      W_DATA: begin
        mem_addr = bp_q;
        if (up_free) begin
          mem_req = 1'b1;
          if (mem_gnt) begin
            up_load = 1'b1;
            bp_n    = bp_q + AW'(1);
            rem_n   = rem_q - LEN_W'(up_nb);
            if (tail) st_n = W_DRAIN;
          end
        end
      end
      W_DRAIN: begin
        if (up_free) st_n = W_WB;
      end
      W_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {16'd0, 16'(len_q)};
        if (mem_gnt) begin
          set_done = 1'b1;
          ptr_n    = eor_q ? base_w : (ptr_q + (cfg_gap ? STRIDE_G : STRIDE_N));
          st_n     = W_STAT;
        end
      end
      default: st_n = W_OFF;
    endcase
    if (!cfg_en) st_n = W_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_OFF;
      ptr_q <= '0;
      bp_q  <= '0;
      len_q <= '0;
      rem_q <= '0;
      eor_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      ptr_q <= ptr_n;
      bp_q  <= bp_n;
      len_q <= len_n;
      rem_q <= rem_n;
      eor_q <= eor_n;
    end
  end

  assign suspended = (st_q == W_WAIT);

  AST_OFF_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !mem_req) else $error("memory access while disabled"); // R9

  AST_WB_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> up_free) else $error("write-back before stream drained"); // R4

endmodule

// File: rtl/txd_unpack.sv
module txd_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [2:0]  nb,
  input  logic        last_in,
  output logic        free,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  logic [31:0] sh_q, sh_n;
  logic [2:0]  cnt_q, cnt_n;
  logic        lst_q, lst_n;
  logic        take;

  assign free     = (cnt_q == 3'd0);
  assign tx_valid = !free;
  assign tx_data  = sh_q[7:0];
  assign tx_last  = lst_q && (cnt_q == 3'd1);
  assign take     = tx_valid && tx_ready;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    lst_n = lst_q;
    if (load) begin
      sh_n  = word;
      cnt_n = nb;
      lst_n = last_in;
    end else if (take) begin
      sh_n  = {8'd0, sh_q[31:8]};
      cnt_n = cnt_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      lst_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      lst_q <= lst_n;
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)))
    else $error("byte changed under backpressure"); // R3

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free) else $error("word loaded over pending bytes"); // R3

endmodule

// File: rtl/ring_tx_dma.sv
module ring_tx_dma #(
  parameter int AW    = 16,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          irq
);
  logic [1:0]    rst_sq;
  logic          rst_s;
  logic          cfg_en, cfg_gap, poll;
  logic [AW-1:0] base_w;
  logic          set_done, set_unav, suspended;
  logic          up_free, up_load, up_last;
  logic [2:0]    up_nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_s = rst_sq[1];

  txd_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .set_done(set_done), .set_unav(set_unav),
    .cfg_en(cfg_en), .cfg_gap(cfg_gap), .base_w(base_w), .poll(poll), .irq(irq)
  );

  txd_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_s),
    .cfg_en(cfg_en), .cfg_gap(cfg_gap), .base_w(base_w), .poll(poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .up_free(up_free), .up_load(up_load), .up_nb(up_nb), .up_last(up_last),
    .set_done(set_done), .set_unav(set_unav), .suspended(suspended)
  );

  txd_unpack u_unpk (
    .clk(clk), .rst_n(rst_s),
    .load(up_load), .word(mem_rdata), .nb(up_nb), .last_in(up_last),
    .free(up_free),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  AST_QUIET_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_s)
    suspended |-> (!tx_valid && !mem_req)) else $error("activity while suspended"); // R7

endmodule

// File: tb/test_ring_tx_dma.sv
module test_ring_tx_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_gnt = 1'b1;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        irq;

  logic [31:0] mem [256];
  logic [7:0]  cap_d [512];
  logic        cap_l [512];
  int          cap_n = 0;
  int          wb_a [32];
  logic [31:0] wb_d [32];
  int          wb_n = 0;
  int          rd_n = 0;
  int          rd_last = -1;
  int          cyc = 0;
  bit          bp_mode = 1'b0;
  int          total = 0;
  int          bad = 0;
  bit          ended = 1'b0;

  always #10 clk = ~clk;

  ring_tx_dma i_ring_tx_dma (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .irq(irq)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_gnt  <= (cyc % 3) != 2;
    tx_ready <= bp_mode ? ((cyc % 5) < 2) : 1'b1;
  end

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        wb_a[wb_n] <= int'(mem_addr);
        wb_d[wb_n] <= mem_wdata;
        wb_n <= wb_n + 1;
      end else begin
        rd_n <= rd_n + 1;
        rd_last <= int'(mem_addr);
      end
    end
    if (tx_valid && tx_ready) begin
      cap_d[cap_n] <= tx_data;
      cap_l[cap_n] <= tx_last;
      cap_n <= cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stat(input logic [31:0] bits);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, v);
      if ((v & bits) == bits) break;
    end
  endtask

  task automatic put_desc(input int w, input bit own, input bit eor, input int len, input int bufw);
    mem[w]   = {own, 31'd0};
    mem[w+1] = {1'b0, eor, 19'd0, 11'(len)};
    mem[w+2] = 32'(bufw * 4);
    mem[w+3] = 32'd0;
  endtask

  task automatic fill_buf(input int bufw, input int len, input int seed);
    for (int i = 0; i < len; i++)
      mem[bufw + i/4][8*(i%4) +: 8] = 8'(seed + i);
  endtask

  task automatic check_frame(input int from, input int len, input int seed, input string tag);
    for (int i = 0; i < len; i++) begin
      check(cap_d[from+i] == 8'(seed + i), {tag, " byte"}, int'(cap_d[from+i]), (seed + i) & 255);
      check(cap_l[from+i] == (i == len - 1), {tag, " last"}, int'(cap_l[from+i]), int'(i == len - 1));
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(!tx_valid, "R1 tx_valid", int'(tx_valid), 0);
    check(!mem_req, "R1 mem_req", int'(mem_req), 0);
    check(!irq, "R1 irq", int'(irq), 0);
    rd(3'd3, v);
    check(v == 0, "R1 status", int'(v), 0);
  endtask

  task automatic t_base_lock();
    logic [31:0] v;
    int n0;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd64);
    wr(3'd0, 32'd1);
    wr(3'd1, 32'h200);
    rd(3'd1, v);
    check(v == 64, "R9 base lock", int'(v), 64);
    n0 = rd_n;
    repeat (20) @(negedge clk);
    check(rd_n == n0 && wb_n == 0, "R9 wait for poll", rd_n, n0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int c0 = cap_n;
    put_desc(16, 1'b1, 1'b0, 7, 100);
    fill_buf(100, 7, 8'h11);
    wr(3'd2, 32'd1);
    wait_stat(32'd2);
    check(cap_n - c0 == 7, "R3 count", cap_n - c0, 7);
    check_frame(c0, 7, 8'h11, "R3");
    check(wb_n == 1 && wb_a[0] == 16, "R4 wb addr", wb_a[0], 16);
    check(wb_d[0] == 32'd7, "R4 wb data", int'(wb_d[0]), 7);
    rd(3'd3, v);
    check(v == 3, "R4 status", int'(v), 3);
    check(rd_last == 20, "R6 stride 4 / R2 own", rd_last, 20);
  endtask

  task automatic t_quiet();
    int n0 = rd_n;
    int c0 = cap_n;
    repeat (30) @(negedge clk);
    check(rd_n == n0 && cap_n == c0, "R7 no access when suspended", rd_n, n0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(3'd4, 32'd0);
    check(!irq, "R8 masked", int'(irq), 0);
    wr(3'd4, 32'd1);
    check(irq, "R8 enabled", int'(irq), 1);
    wr(3'd3, 32'd1);
    rd(3'd3, v);
    check(v == 2, "R8 w1c", int'(v), 2);
    check(!irq, "R8 cleared", int'(irq), 0);
    wr(3'd4, 32'd3);
    check(irq, "R8 unavail irq", int'(irq), 1);
    wr(3'd3, 32'd2);
    rd(3'd3, v);
    check(v == 0 && !irq, "R8 all clear", int'(v), 0);
    wr(3'd4, 32'd0);
  endtask

  task automatic t_backpressure();
    int c0 = cap_n;
    int w0 = wb_n;
    put_desc(20, 1'b1, 1'b0, 10, 110);
    fill_buf(110, 10, 8'h40);
    bp_mode = 1'b1;
    wr(3'd2, 32'd1);
    wait_stat(32'd3);
    bp_mode = 1'b0;
    check(cap_n - c0 == 10, "R3 bp count", cap_n - c0, 10);
    check_frame(c0, 10, 8'h40, "R3 bp");
    check(wb_a[w0] == 20 && wb_d[w0] == 10, "R7 reread after poll", wb_a[w0], 20);
    wr(3'd3, 32'd3);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int c0 = cap_n;
    int w0 = wb_n;
    put_desc(24, 1'b1, 1'b0, 0, 0);
    wr(3'd2, 32'd1);
    wait_stat(32'd3);
    check(cap_n == c0, "R5 no bytes", cap_n, c0);
    check(wb_n == w0 + 1 && wb_a[w0] == 24, "R5 wb addr", wb_a[w0], 24);
    check(wb_d[w0] == 0, "R5 wb data", int'(wb_d[w0]), 0);
    rd(3'd3, v);
    check(v == 3, "R5 done", int'(v), 3);
    wr(3'd3, 32'd3);
  endtask

  task automatic t_eor();
    int c0 = cap_n;
    put_desc(28, 1'b1, 1'b1, 3, 120);
    fill_buf(120, 3, 8'h80);
    wr(3'd2, 32'd1);
    wait_stat(32'd3);
    check_frame(c0, 3, 8'h80, "R6 eor");
    check(rd_last == 16, "R6 wrap to base", rd_last, 16);
    wr(3'd3, 32'd3);
  endtask

  task automatic t_gap();
    int c0 = cap_n;
    int w0 = wb_n;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd160);
    wr(3'd0, 32'd3);
    put_desc(40, 1'b1, 1'b0, 2, 130);
    fill_buf(130, 2, 8'hA0);
    put_desc(48, 1'b1, 1'b0, 5, 132);
    fill_buf(132, 5, 8'hC0);
    put_desc(56, 1'b0, 1'b0, 0, 0);
    wr(3'd2, 32'd1);
    wait_stat(32'd3);
    check(wb_a[w0] == 40, "R9 start at new base", wb_a[w0], 40);
    check(wb_a[w0+1] == 48, "R6 stride 8", wb_a[w0+1], 48);
    check(rd_last == 56, "R6 stride 8 next", rd_last, 56);
    check(cap_n - c0 == 7, "R3 gap count", cap_n - c0, 7);
    check_frame(c0, 2, 8'hA0, "R3 gap f1");
    check_frame(c0 + 2, 5, 8'hC0, "R3 gap f2");
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_base_lock();
    t_single();
    t_quiet();
    t_irq();
    t_backpressure();
    t_zero();
    t_eor();
    t_gap();
    finish_run();
  end

endmodule